// File: doc/BRIEF.md
# Pixel Rectangle Mover

This block copies a rectangle of 16-bit pixels between a stream of 32-bit words and a frame memory of 1024 columns by 512 rows, in either direction. A one-cycle start strobe hands it a position word, a size word and a direction bit. From then on the block works in one of two ways. For a write, it takes words from an input stream, splits each word into two pixels and stores them. For a read, it fetches pixels, packs them in pairs and offers them as words on an output stream.

The rectangle is walked row by row, left to right. Columns wrap inside the 1024-pixel line, and rows wrap at the bottom of the 512-line frame. The walk position lives entirely in the block. Either stream may stall at any word, including in the middle of a row, and the transfer continues from the saved column when words flow again. A read raises an image-ready flag for as long as its data is pending. A write ends with a one-cycle completion pulse that reports the rectangle as it was given at start.

Top module: `vram_rect_mover`

## Requirements
- R1: The start column is taken from position bits 9:0 and the start row from position bits 24:16. All other position bits are ignored.
- R2: The width is size bits 9:0 and the height is size bits 24:16. A width field of 0 means 1024 and a height field of 0 means 512. Size bits 15:10 and 31:25 are ignored.
- R3: Pixels go to or come from memory address row*1024+column. The low halfword of a stream word is the earlier pixel in the walk, and the high halfword is the later one.
- R4: After the last row of the frame (row 511), the next row of the rectangle is row 0.
- R5: Within a row, the column wraps from 1023 back to 0.
- R6: When the input stream pauses mid-row, no pixel is lost or repeated. The next word continues at the saved column of the same row.
- R7: During a read, image-ready and busy go high in the cycle after start. Both fall once the final word has been taken from the output stream.
- R8: The first word offered by a read carries the rectangle's first two pixels, low halfword first, before any word has been consumed.
- R9: A write ends with a single-cycle done pulse. Busy is already low in that cycle, and the done outputs carry the start column, start row, width (1..1024) and height (1..512).
- R10: When the pixel count is odd, the high halfword of the last write word is not stored, and the high halfword of the last read word is zero.
- R11: While the output word is valid and not accepted, it stays valid and does not change.
- R12: After reset, busy, image-ready, done, the input-ready and output-valid signals, and the memory enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer start strobe |
| start_pos | input | 32 | Position word |
| start_size | input | 32 | Size word |
| start_rd | input | 1 | 1 = read from memory, 0 = write to memory |
| wr_valid | input | 1 | Input word valid |
| wr_data | input | 32 | Input word, two pixels |
| wr_ready | output | 1 | Block can take an input word |
| rd_valid | output | 1 | Output word valid |
| rd_data | output | 32 | Output word, two pixels |
| rd_ready | input | 1 | Consumer takes the output word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 19 | Pixel address row*1024+column |
| mem_wdata | output | 16 | Pixel to store |
| mem_rdata | input | 16 | Pixel read, valid one cycle after the access |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read data pending |
| done | output | 1 | Write completion pulse |
| done_x | output | 10 | Start column of the finished write |
| done_y | output | 9 | Start row of the finished write |
| done_w | output | 11 | Width of the finished write |
| done_h | output | 10 | Height of the finished write |

## Verification
A wrong column offset or row counter shows on mem_addr at the very next pixel access, so each access is compared against the rectangle walk. A wrong halfword select shows up as swapped pixel data in the first word that follows. A bad remaining-row count appears only at the end of a transfer: the done pulse or the fall of image-ready comes early or late, or extra accesses occur. For that reason the bench checks the state at the end of every transfer and checks that no memory access remains unaccounted for.

// File: rtl/vram_rect_mover.sv
module vram_rect_mover #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     start_pos,
  input  logic [31:0]     start_size,
  input  logic            start_rd,
  input  logic            wr_valid,
  input  logic [2*PW-1:0] wr_data,
  output logic            wr_ready,
  output logic            rd_valid,
  output logic [2*PW-1:0] rd_data,
  input  logic            rd_ready,
  output logic            mem_en,
  output logic            mem_we,
  output logic [XW+YW-1:0] mem_addr,
  output logic [PW-1:0]   mem_wdata,
  input  logic [PW-1:0]   mem_rdata,
  output logic            busy,
  output logic            img_ready,
  output logic            done,
  output logic [XW-1:0]   done_x,
  output logic [YW-1:0]   done_y,
  output logic [XW:0]     done_w,
  output logic [YW:0]     done_h
);

  logic            active, is_rd, have_word, half, rvalid_q, done_q;
  logic [XW-1:0]   x0, col;
  logic [YW-1:0]   y0, row;
  logic [XW:0]     w;
  logic [YW:0]     h, rows;
  logic [1:0]      rstep;
  logic [PW-1:0]   lo, hi;
  logic [2*PW-1:0] wbuf;

  wire [XW-1:0] wm1 = start_size[XW-1:0] - 1'b1;
  wire [YW-1:0] hm1 = start_size[16+:YW] - 1'b1;

  wire last_col = ({1'b0, col} + 1'b1) == w;
  wire fin      = last_col && (rows == 1);
  wire wr_px    = active && !is_rd && have_word;
  wire rd_px    = active && is_rd && !rvalid_q && (rows != 0) && (rstep != 2'd2);
  wire step     = wr_px || rd_px;
  wire [XW-1:0] xcur = x0 + col;

  assign wr_ready  = active && !is_rd && !have_word;
  assign rd_valid  = rvalid_q;
  assign rd_data   = {hi, lo};
  assign mem_en    = step;
  assign mem_we    = wr_px;
  assign mem_addr  = {row, xcur};
  assign mem_wdata = half ? wbuf[2*PW-1:PW] : wbuf[PW-1:0];
  assign busy      = active;
  assign img_ready = active && is_rd;
  assign done      = done_q;
  assign done_x    = x0;
  assign done_y    = y0;
  assign done_w    = w;
  assign done_h    = h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; is_rd <= 1'b0; have_word <= 1'b0; half <= 1'b0;
      rvalid_q <= 1'b0; done_q <= 1'b0; rstep <= 2'd0;
      x0 <= '0; y0 <= '0; col <= '0; row <= '0; w <= '0; h <= '0; rows <= '0;
      lo <= '0; hi <= '0; wbuf <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        is_rd     <= start_rd;
        x0        <= start_pos[XW-1:0];
        y0        <= start_pos[16+:YW];
        row       <= start_pos[16+:YW];
        col       <= '0;
        w         <= {1'b0, wm1} + 1'b1;
        h         <= {1'b0, hm1} + 1'b1;
        rows      <= {1'b0, hm1} + 1'b1;
        have_word <= 1'b0;
        half      <= 1'b0;
        rvalid_q  <= 1'b0;
        rstep     <= 2'd0;
      end else begin
        if (step) begin
          if (last_col) begin
            col  <= '0;
            row  <= row + 1'b1;
            rows <= rows - 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end
        if (wr_ready && wr_valid) begin
          wbuf      <= wr_data;
          have_word <= 1'b1;
          half      <= 1'b0;
        end
        if (wr_px) begin
          if (fin) begin
            active    <= 1'b0;
            have_word <= 1'b0;
            done_q    <= 1'b1;
          end else if (half) begin
            have_word <= 1'b0;
          end else begin
            half <= 1'b1;
          end
        end
        if (active && is_rd) begin
          case (rstep)
            2'd0: if (rd_px) rstep <= 2'd1;
            2'd1: begin
              lo <= mem_rdata;
              if (rows == 0) begin
                hi       <= '0;
                rvalid_q <= 1'b1;
                rstep    <= 2'd0;
              end else begin
                rstep <= 2'd2;
              end
            end
            default: begin
              hi       <= mem_rdata;
              rvalid_q <= 1'b1;
              rstep    <= 2'd0;
            end
          endcase
          if (rvalid_q && rd_ready) begin
            rvalid_q <= 1'b0;
            if (rows == 0) active <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/vram_rect_mover_chk.sv
module vram_rect_mover_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_data,
  input logic        mem_en,
  input logic        mem_we,
  input logic        busy,
  input logic        img_ready,
  input logic        done
);

  // R7
  img_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !img_ready);

  // R11
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !start |=> rd_valid && $stable(rd_data));

  // R3
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en && busy && !img_ready);

  // R6
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid));

  // R12
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

endmodule

bind vram_rect_mover vram_rect_mover_chk u_chk (.*);

// File: tb/tb_vram_rect_mover.sv
`timescale 1ns/1ps
module tb_vram_rect_mover;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, start_rd, wr_valid, rd_ready;
  logic [31:0] start_pos, start_size, wr_data;
  logic        wr_ready, rd_valid, mem_en, mem_we, busy, img_ready, done;
  logic [31:0] rd_data;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [9:0]  done_x;
  logic [8:0]  done_y;
  logic [10:0] done_w;
  logic [9:0]  done_h;

  vram_rect_mover dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [15:0] vmem [int];
  logic [34:0] exp_wq [$];
  logic [31:0] exp_rq [$];

  function automatic logic [15:0] rdm(int a);
    return vmem.exists(a) ? vmem[a] : 16'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) vmem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= rdm(int'(mem_addr));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  logic        pv = 0, pr = 0;
  logic [31:0] pd = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_en && mem_we) begin
        if (exp_wq.size() == 0)
          chk(0, "R10", "unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [34:0] e;
          e = exp_wq.pop_front();
          chk({mem_addr, mem_wdata} == e, "R3", "write addr/data", {mem_addr, mem_wdata}, e);
        end
      end
      if (rd_valid && rd_ready) begin
        if (exp_rq.size() == 0)
          chk(0, "R7", "unexpected read word", rd_data, 0);
        else begin
          logic [31:0] e;
          e = exp_rq.pop_front();
          chk(rd_data == e, "R3", "read word", rd_data, e);
        end
      end
      if (pv && !pr)
        chk(rd_valid && rd_data == pd, "R11", "stalled word held", {rd_valid, rd_data}, {1'b1, pd});
      pv = rd_valid; pr = rd_ready; pd = rd_data;
    end
  end

  function automatic int fw(logic [31:0] s); return s[9:0] == 0 ? 1024 : int'(s[9:0]); endfunction
  function automatic int fh(logic [31:0] s); return s[24:16] == 0 ? 512 : int'(s[24:16]); endfunction

  task automatic do_start(logic [31:0] pos, logic [31:0] size, logic rd);
    start_pos = pos; start_size = size; start_rd = rd; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run_write(logic [31:0] pos, logic [31:0] size, int gap_every, int seed);
    int w = fw(size), h = fh(size), x0 = int'(pos[9:0]), y0 = int'(pos[24:16]);
    logic [15:0] px [$];
    int idx = 0, t = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int a = ((y0 + r) % 512) * 1024 + ((x0 + c) % 1024);
        logic [15:0] d = 16'(seed + idx * 37);
        exp_wq.push_back({19'(a), d});
        px.push_back(d);
        idx++;
      end
    if (px.size() % 2) px.push_back(16'hBEEF);
    do_start(pos, size, 1'b0);
    for (int k = 0; k < px.size() / 2; k++) begin
      bit hs;
      wr_data = {px[2*k+1], px[2*k]};
      wr_valid = 1'b1;
      do begin
        @(negedge clk); hs = wr_ready;
        tick();
      end while (!hs);
      if (gap_every > 0 && (k % gap_every) == gap_every - 1) begin
        wr_valid = 1'b0;
        repeat (5) tick();
      end
    end
    wr_valid = 1'b0;
    @(negedge clk);
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, "R9", "done pulse seen", done, 1);
    chk(!busy, "R9", "busy low at done", busy, 0);
    chk(done_x == pos[9:0] && done_y == pos[24:16], "R1", "done position", {done_x, done_y}, {pos[9:0], pos[24:16]});
    chk(done_w == 11'(w) && done_h == 10'(h), "R2", "done size", {done_w, done_h}, {11'(w), 10'(h)});
    @(negedge clk);
    chk(!done, "R9", "done single cycle", done, 0);
    chk(exp_wq.size() == 0, "R6", "all pixels written", exp_wq.size(), 0);
  endtask

  task automatic run_read(logic [31:0] pos, logic [31:0] size, bit stall, int seed);
    int w = fw(size), h = fh(size), x0 = int'(pos[9:0]), y0 = int'(pos[24:16]);
    logic [15:0] px [$];
    int k = 0, t = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int a = ((y0 + r) % 512) * 1024 + ((x0 + c) % 1024);
        logic [15:0] d = 16'(seed + px.size() * 13);
        vmem[a] = d;
        px.push_back(d);
      end
    if (px.size() % 2) px.push_back(16'h0000);
    for (int i = 0; i < px.size() / 2; i++) exp_rq.push_back({px[2*i+1], px[2*i]});
    rd_ready = 1'b0;
    do_start(pos, size, 1'b1);
    @(negedge clk);
    chk(img_ready && busy, "R7", "image-ready after start", {img_ready, busy}, 2'b11);
    while (!rd_valid && t < 50) begin @(negedge clk); t++; end
    chk(rd_data == {px[1], px[0]}, "R8", "first word preloaded", rd_data, {px[1], px[0]});
    tick();
    t = 0;
    while (exp_rq.size() > 0 && t < 20000) begin
      rd_ready = stall ? (k % 3 != 0) : 1'b1;
      k++; t++;
      tick();
    end
    rd_ready = 1'b0;
    @(negedge clk);
    chk(!img_ready && !busy, "R7", "image-ready cleared", {img_ready, busy}, 2'b00);
    chk(exp_rq.size() == 0, "R10", "all words read", exp_rq.size(), 0);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; start_rd = 0; start_pos = 0; start_size = 0;
    wr_valid = 0; wr_data = 0; rd_ready = 0; mem_rdata = 0;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    // R12
    chk(!busy && !img_ready && !done && !wr_ready && !rd_valid && !mem_en, "R12", "reset state",
        {busy, img_ready, done, wr_ready, rd_valid, mem_en}, 0);
    tick();
    // R1 R3: junk in unused position bits
    run_write(32'hFE03_FC05, 32'h0003_0004, 0, 100);
    // R4: row wrap
    run_write(32'h01FE_0010, 32'h0004_0002, 0, 200);
    // R5 R10: column wrap, odd count
    run_write(32'h0002_03FE, 32'h0001_0005, 0, 300);
    // R6: pauses mid-row
    run_write(32'h0040_0020, 32'h0003_0007, 2, 400);
    // R2: width field zero with junk in bits 15:10
    run_write(32'h0009_0000, 32'h0001_FC00, 0, 500);
    // R8 R10 R11: read odd count with stalls
    run_read(32'h0014_0064, 32'h0003_0003, 1, 600);
    // R2 R4: height field zero, rows wrap
    run_read(32'h0007_0011, 32'h0000_0001, 0, 700);
    // R5: read column wrap
    run_read(32'h0030_03FD, 32'h0002_0004, 1, 800);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule